// File: doc/BRIEF.md
# Pixel Clock Synthesizer Divider Calculator

This block turns a requested pixel clock frequency, given in Hz as a 32-bit unsigned number, into the settings for a clock synthesizer whose output moves in steps of 921,600 Hz. That step is a 14,745,600 Hz reference divided by 16. The block first picks a power-of-two post-divider N from three frequency thresholds. It then finds the feedback multiplier M, rounded to the nearest step, and packs the post-divider code and M into one 16-bit control word for a three-wire programming port.

A caller drives `fout_hz` and pulses `start`. The block samples the request on that edge and runs an iterative restoring divider that settles one quotient bit per cycle. It pulses `done` when the word is ready. The result stays on the outputs until the next accepted request finishes. Shifting the word out to the synthesizer is done elsewhere.

Top module: `pixclk_divcalc`

## Requirements
- R1: The post-divider code in `ctrl_word` bits 10:9 is 3 (N=8) when fout < 50,169,600. It is 2 (N=4) when fout < 100,339,199, and 1 (N=2) when fout < 200,678,399. In every other case it is 0 (N=1).
- R2: `ctrl_word` bits 8:0 hold M = floor((fout·N + 460,800) / 921,600), so a remainder of exactly half a step rounds up.
- R3: When M is above 511, `overflow` is 1 and bits 8:0 saturate to 511. Otherwise `overflow` is 0.
- R4: `ctrl_word` bits 15:11 are always 0.
- R5: `done` is a one-cycle pulse. It appears 41 clock edges after the edge that accepted `start`, and `busy` is high from the edge after acceptance until the edge that raises `done`.
- R6: A `start` while `busy` is high is ignored. The running computation finishes on schedule with the first request's result and produces exactly one `done`.
- R7: `ctrl_word` and `overflow` keep their values between `done` pulses.
- R8: After reset, `busy`, `done`, `overflow` and `ctrl_word` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse; `fout_hz` is sampled when accepted |
| fout_hz | input | 32 | Requested output frequency in Hz |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result-valid pulse |
| ctrl_word | output | 16 | Packed {5'b0, post-divider code, M} |
| overflow | output | 1 | M did not fit in 9 bits (saturated) |

## Verification
The hardest case to reach is a start that arrives while busy is high, partway through a computation. The second request must be dropped without disturbing the partial remainder and without producing a second done. The bench aims at this directly: it issues one request, waits a dozen cycles, raises start again with a frequency in a different range, and then checks for a single done pulse on time carrying the first request's values. The other hard cases are the exact rounding ties and the frequencies one hertz on either side of each threshold and of the overflow point. Random values seldom land there, so the bench applies them as directed cases.

// File: rtl/pixclk_pkg.sv
package pixclk_pkg;

   // Post-divider code as placed in the control word; N = 2**code.
   typedef enum logic [1:0] {
      PDIV_1 = 2'd0,
      PDIV_2 = 2'd1,
      PDIV_4 = 2'd2,
      PDIV_8 = 2'd3
   } pdiv_code_e;

endpackage

// File: rtl/pixclk_pdiv_sel.sv
module pixclk_pdiv_sel
   import pixclk_pkg::*;
#(
   parameter int unsigned FREQ_W = 32,
   parameter logic [FREQ_W-1:0] LIM_N8 = FREQ_W'(50169600),
   parameter logic [FREQ_W-1:0] LIM_N4 = FREQ_W'(100339199),
   parameter logic [FREQ_W-1:0] LIM_N2 = FREQ_W'(200678399)
) (
   input  logic [FREQ_W-1:0] fout,
   output pdiv_code_e        code
);

   // Thresholds are checked lowest first: the smallest band wins.
   always_comb begin
      if (fout < LIM_N8)      code = PDIV_8;
      else if (fout < LIM_N4) code = PDIV_4;
      else if (fout < LIM_N2) code = PDIV_2;
      else                    code = PDIV_1;
   end

endmodule

// File: rtl/pixclk_rdiv.sv
module pixclk_rdiv #(
   parameter int unsigned DIVIDEND_W = 40,
   parameter int unsigned DIVISOR    = 921600,
   localparam int unsigned DVS_W     = $clog2(DIVISOR + 1),
   localparam int unsigned CNT_W     = $clog2(DIVIDEND_W)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [DIVIDEND_W-1:0] dividend,
   output logic [DIVIDEND_W-1:0] quotient,
   output logic                  fin
);

   localparam logic [DVS_W:0]   DVS      = (DVS_W+1)'(DIVISOR);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DIVIDEND_W - 1);

   logic [DIVIDEND_W-1:0] q_r;
   logic [DVS_W-1:0]      rem_r;
   logic [CNT_W-1:0]      cnt_r;
   logic                  run_r;
   logic                  fin_r;

   logic [DVS_W:0] trial;
   logic [DVS_W:0] diff;
   logic           fits;

   // One restoring step: bring down the next dividend bit, try subtract.
   always_comb begin
      trial = {rem_r, q_r[DIVIDEND_W-1]};
      diff  = trial - DVS;
      fits  = (trial >= DVS);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_r   <= '0;
         rem_r <= '0;
         cnt_r <= '0;
         run_r <= 1'b0;
         fin_r <= 1'b0;
      end else if (load) begin
         q_r   <= dividend;
         rem_r <= '0;
         cnt_r <= '0;
         run_r <= 1'b1;
         fin_r <= 1'b0;
      end else if (run_r) begin
         q_r   <= {q_r[DIVIDEND_W-2:0], fits};
         rem_r <= fits ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
         cnt_r <= cnt_r + 1'b1;
         if (cnt_r == LAST_BIT) begin
            run_r <= 1'b0;
            fin_r <= 1'b1;
         end
      end else begin
         fin_r <= 1'b0;
      end
   end

   assign quotient = q_r;
   assign fin      = fin_r;

endmodule

// File: rtl/pixclk_divcalc.sv
module pixclk_divcalc
   import pixclk_pkg::*;
#(
   parameter int unsigned FREQ_W   = 32,
   parameter int unsigned REF_HZ   = 14745600,
   parameter int unsigned STEP_DIV = 16,
   parameter int unsigned DIV_W    = 40,
   parameter int unsigned M_W      = 9,
   parameter int unsigned WORD_W   = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [FREQ_W-1:0] fout_hz,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] ctrl_word,
   output logic              overflow
);

   localparam int unsigned STEP_HZ = REF_HZ / STEP_DIV;
   localparam int unsigned HALF_HZ = STEP_HZ / 2;

   // Elaboration-time parameter checks.
   if (DIV_W < FREQ_W + 4) begin : g_chk_divw
      $error("DIV_W must hold fout*8 plus half a step");
   end
   if (WORD_W < M_W + 2) begin : g_chk_word
      $error("WORD_W too small for code and multiplier");
   end
   if (STEP_HZ == 0) begin : g_chk_step
      $error("step frequency must be nonzero");
   end

   pdiv_code_e             sel_code;
   pdiv_code_e             code_r;
   logic [DIV_W-1:0]       dividend;
   logic [DIV_W-1:0]       quot;
   logic                   div_fin;
   logic                   accept;
   logic                   busy_r;
   logic                   done_r;
   logic                   ovf_r;
   logic [WORD_W-1:0]      word_r;
   logic                   m_big;
   logic [M_W-1:0]         m_field;

   pixclk_pdiv_sel #(.FREQ_W(FREQ_W)) u_sel (
      .fout (fout_hz),
      .code (sel_code)
   );

   // N is a power of two, so the scaling is a shift by the code.
   assign dividend = (DIV_W'(fout_hz) << sel_code) + DIV_W'(HALF_HZ);
   assign accept   = start && !busy_r;

   pixclk_rdiv #(.DIVIDEND_W(DIV_W), .DIVISOR(STEP_HZ)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .dividend (dividend),
      .quotient (quot),
      .fin      (div_fin)
   );

   assign m_big = |quot[DIV_W-1:M_W];

   if (SATURATE) begin : g_sat
      assign m_field = m_big ? {M_W{1'b1}} : quot[M_W-1:0];
   end else begin : g_wrap
      assign m_field = quot[M_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_r <= PDIV_1;
         busy_r <= 1'b0;
         done_r <= 1'b0;
         ovf_r  <= 1'b0;
         word_r <= '0;
      end else begin
         done_r <= 1'b0;
         if (accept) begin
            code_r <= sel_code;
            busy_r <= 1'b1;
         end else if (busy_r && div_fin) begin
            busy_r <= 1'b0;
            done_r <= 1'b1;
            ovf_r  <= m_big;
            word_r <= WORD_W'({code_r, m_field});
         end
      end
   end

   assign busy      = busy_r;
   assign done      = done_r;
   assign ctrl_word = word_r;
   assign overflow  = ovf_r;

endmodule

// File: rtl/pixclk_divcalc_chk.sv
module pixclk_divcalc_chk #(
   parameter int unsigned DIV_W  = 40,
   parameter int unsigned M_W    = 9,
   parameter int unsigned WORD_W = 16,
   localparam int unsigned LAT   = DIV_W + 1,
   localparam int unsigned LC_W  = $clog2(DIV_W + 4)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              overflow,
   input logic [WORD_W-1:0] ctrl_word
);

   // Edges since the accepting edge, counted while busy.
   logic [LC_W-1:0] lat_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)                lat_cnt <= '0;
      else if (start && !busy)   lat_cnt <= LC_W'(1);
      else if (busy)             lat_cnt <= lat_cnt + 1'b1;
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                              // R5
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $fell(busy));                                 // R5
   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (lat_cnt == LC_W'(LAT + 1)));                 // R5
   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);                                   // R5
   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && lat_cnt < LC_W'(LAT)) |=> busy);             // R6
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> (ctrl_word[M_W-1:0] == {M_W{1'b1}}));           // R3
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_word[WORD_W-1:M_W+2] == '0);                             // R4
   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(ctrl_word) && $stable(overflow)));         // R7

endmodule

bind pixclk_divcalc pixclk_divcalc_chk #(
   .DIV_W(DIV_W), .M_W(M_W), .WORD_W(WORD_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .overflow  (overflow),
   .ctrl_word (ctrl_word)
);

// File: tb/pixclk_divcalc_bench.sv
module pixclk_divcalc_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] fout_hz = '0;
   logic        busy;
   logic        done;
   logic [15:0] ctrl_word;
   logic        overflow;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;   // 250 MHz

   pixclk_divcalc u_pixclk_divcalc (
      .clk(clk), .rst_n(rst_n), .start(start), .fout_hz(fout_hz),
      .busy(busy), .done(done), .ctrl_word(ctrl_word), .overflow(overflow)
   );

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic void model(input logic [31:0] f,
                                 output logic [15:0] w, output logic ovf);
      int unsigned code;
      longint unsigned a, m;
      if (f < 32'd50169600)       code = 3;
      else if (f < 32'd100339199) code = 2;
      else if (f < 32'd200678399) code = 1;
      else                        code = 0;
      a = ({32'b0, f} << code) + 64'd460800;
      m = a / 64'd921600;
      ovf = (m > 64'd511);
      if (ovf) m = 64'd511;
      w = {5'b0, code[1:0], m[8:0]};
   endfunction

   task automatic run(input logic [31:0] f, input bool_intrude, input logic [31:0] f2);
      logic [15:0] ew, ew2;
      logic eo, eo2;
      int lat = 0;
      model(f, ew, eo);
      model(f2, ew2, eo2);
      @(negedge clk);
      fout_hz = f;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      fout_hz = f2;
      lat = 1;
      while (!done && lat < 100) begin
         if (bool_intrude && lat == 12) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            lat++;
            check("R6 busy after ignored start", busy, 1);
         end else begin
            @(negedge clk);
            if (!done) lat++;
         end
      end
      check("R5 latency", lat, 41);
      check("R1 code", ctrl_word[10:9], ew[10:9]);
      check("R2 multiplier", ctrl_word[8:0], ew[8:0]);
      check("R3 overflow", overflow, eo);
      check("R4 upper bits", ctrl_word[15:11], 0);
      check("R5 busy cleared", busy, 0);
      @(negedge clk);
      check("R5 done width", done, 0);
      if (bool_intrude) begin
         repeat (45) begin
            @(negedge clk);
            check("R6 no second done", done, 0);
         end
         check("R6 first request kept", ctrl_word, ew);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [15:0] held;
      repeat (4) @(negedge clk);
      check("R8 busy reset", busy, 0);
      check("R8 done reset", done, 0);
      check("R8 overflow reset", overflow, 0);
      check("R8 word reset", ctrl_word, 0);
      rst_n = 1'b1;

      // Threshold edges (R1), rounding ties (R2), overflow edge (R3).
      run(32'd0, 0, 0);
      run(32'd50169599, 0, 0);
      run(32'd50169600, 0, 0);
      run(32'd100339198, 0, 0);
      run(32'd100339199, 0, 0);
      run(32'd200678398, 0, 0);
      run(32'd200678399, 0, 0);
      run(32'd57599, 0, 0);
      run(32'd57600, 0, 0);
      run(32'd25180000, 0, 0);
      run(32'd471398399, 0, 0);
      run(32'd471398400, 0, 0);
      run(32'hFFFF_FFFF, 0, 0);

      // R6: second start mid-computation, different band.
      run(32'd25180000, 1, 32'd300000000);
      run(32'd480000000, 1, 32'd1000);

      // R7: outputs hold after done.
      held = ctrl_word;
      repeat (20) @(negedge clk);
      check("R7 word held", ctrl_word, held);
      check("R7 overflow held", overflow, 1);

      void'($urandom(32'd20240517));
      for (int i = 0; i < 60; i++) begin
         logic [31:0] f;
         f = (i % 2 == 0) ? $urandom_range(0, 210000000) : $urandom;
         run(f, 0, 0);
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule